// File: doc/BRIEF.md
# Masked-Header Serial Frame Receiver

This block takes a serial bit stream whose bit clock comes from an external modem and turns it into bytes written into a circular buffer. Both the modem clock and the data line are brought into the system clock domain through two-flop synchronizers. Each rising edge of the synchronized modem clock yields one data bit. Bits are assembled most-significant first.

In free-running mode every assembled byte is offered to the buffer. In synchronized mode the block first hunts for a 16-bit header. The serial history is compared against a programmed pattern, and a mask selects which bits take part in the compare. When the header matches, the block captures exactly `frame_len` bytes. It then signals the end of the frame and goes back to hunting.

The buffer write port is a valid/ready stream that carries the buffer slot address along with the byte. The serial source cannot be stalled, so back-pressure cannot slow the incoming stream. A byte that completes while the previous byte is still waiting on the port is discarded.

Top module: `hdr_frame_rx`

## Requirements
- R1: Bits are sampled on rising edges of `ser_clk`, as seen after synchronization, and are assembled MSB first. The first sampled bit of a byte lands in `wr_data[7]`.
- R2: With `sync_mode` = 0, every 8 sampled bits produce one byte on the write port. No header is needed.
- R3: With `sync_mode` = 1, no byte is produced until the last received bits match `hdr_pattern` in every position where `hdr_mask` is 1. Positions where the mask is 0 are ignored. The most recent bit is bit 0 of the compared history.
- R4: The header compare is only made once at least 15 bits have been sampled since reset, since enable, or since the end of the previous frame. A match that appears in fewer bits does not synchronize the block.
- R5: After a header match, the next `frame_len` bytes are produced. Bits that arrive after the last of them are not stored until a new header match. A `frame_len` of 0 means 256 bytes.
- R6: `frame_done` is a one-cycle pulse. It rises in the same cycle that `wr_valid` presents the last byte of a synchronized frame. It never pulses in free-running mode.
- R7: `wr_addr` starts at 0. It increments by one on each accepted transfer (`wr_valid` and `wr_ready` both high) and wraps from BUF_DEPTH-1 to 0. With the default BUF_DEPTH of 8, it wraps from 7 to 0.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_data` and `wr_addr` hold steady. A byte that completes during that time is dropped and does not consume an address.
- R9: Holding `enable` low clears the write address to 0, clears `wr_valid`, drops any header lock, and discards partial bytes and header history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the modem clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Receiver run; low clears all state |
| sync_mode | input | 1 | 0 = free-running, 1 = header synchronized |
| ser_clk | input | 1 | Modem bit clock (asynchronous) |
| ser_dat | input | 1 | Modem serial data |
| hdr_pattern | input | 16 | Header value to hunt for |
| hdr_mask | input | 16 | Header compare mask; 1 = bit compared |
| frame_len | input | 8 | Bytes captured after each header |
| wr_valid | output | 1 | Byte available on the write port |
| wr_ready | input | 1 | Buffer accepts the byte |
| wr_addr | output | $clog2(BUF_DEPTH) | Buffer slot for `wr_data` |
| wr_data | output | 8 | Assembled byte |
| frame_done | output | 1 | Pulse with the last byte of a frame |

## Verification
A bit counter or shift register that is off by one shows at once on the first byte. That byte comes out rotated, or one bit-time early or late. A wrong header-gate state has two possible signs. The block may store bytes before the header, visible within eight bit-times. Or it may keep storing after `frame_len` bytes, visible as an extra write and a missing `frame_done`. A write index that drifts appears on the next accepted transfer, as a skipped or repeated `wr_addr`. The directed tests make each of these visible: they use a short buffer, a gap of deliberately near-matching bits before a header, and a stalled sink.

// File: rtl/frx_pkg.sv
package frx_pkg;
  localparam int HDR_W  = 16;
  localparam int BYTE_W = 8;
  typedef enum logic {MODE_FREE = 1'b0, MODE_SYNC = 1'b1} frx_mode_e;
endpackage

// File: rtl/frx_edge_sync.sv
module frx_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic ser_dat,
  output logic bit_stb,
  output logic bit_val
);
  logic [2:0] clk_q;
  logic [1:0] dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q <= '0;
      dat_q <= '0;
    end else begin
      clk_q <= {clk_q[1:0], ser_clk};
      dat_q <= {dat_q[0], ser_dat};
    end
  end

  assign bit_stb = clk_q[1] & ~clk_q[2];
  assign bit_val = dat_q[1];
endmodule

// File: rtl/frx_deframer.sv
module frx_deframer
  import frx_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              sync_mode,
  input  logic [HDR_W-1:0]  hdr_pattern,
  input  logic [HDR_W-1:0]  hdr_mask,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              bit_stb,
  input  logic              bit_val,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_val,
  output logic              last_stb
);
  localparam int CNT_W   = $clog2(HDR_W);
  localparam int CNT_MAX = HDR_W - 1;

  logic [BYTE_W-1:0] byte_sh, byte_nx;
  logic [HDR_W-1:0]  hist_sh, hist_nx;
  logic [CNT_W-1:0]  bit_cnt, cnt_nx;
  logic [LEN_W-1:0]  remain;
  logic              locked, hunting, hit;

  always_comb begin
    byte_nx  = {byte_sh[BYTE_W-2:0], bit_val};
    hist_nx  = {hist_sh[HDR_W-2:0], bit_val};
    cnt_nx   = (bit_cnt < CNT_W'(CNT_MAX)) ? bit_cnt + 1'b1 : bit_cnt;
    hunting  = (sync_mode == MODE_SYNC) && !locked;
    hit      = ((hist_nx ^ hdr_pattern) & hdr_mask) == '0;
    byte_stb = bit_stb && enable && !hunting && (cnt_nx == CNT_W'(BYTE_W));
    last_stb = byte_stb && (sync_mode == MODE_SYNC) && (remain == LEN_W'(1));
    byte_val = byte_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_sh <= '0;
      hist_sh <= '0;
      bit_cnt <= '0;
      remain  <= '0;
      locked  <= 1'b0;
    end else if (!enable) begin
      byte_sh <= '0;
      hist_sh <= '0;
      bit_cnt <= '0;
      remain  <= '0;
      locked  <= 1'b0;
    end else if (bit_stb) begin
      byte_sh <= byte_nx;
      hist_sh <= hist_nx;
      bit_cnt <= cnt_nx;
      if (hunting) begin
        if (cnt_nx == CNT_W'(CNT_MAX) && hit) begin
          locked  <= 1'b1;
          bit_cnt <= '0;
          byte_sh <= '0;
          remain  <= frame_len;
        end
      end else if (byte_stb) begin
        bit_cnt <= '0;
        byte_sh <= '0;
        if (sync_mode == MODE_SYNC) begin
          remain <= remain - 1'b1;
          if (remain == LEN_W'(1)) begin
            locked  <= 1'b0;
            hist_sh <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/frx_wr_port.sv
module frx_wr_port
  import frx_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              last_stb,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              frame_done
);
  logic xfer, can_load;

  assign xfer     = wr_valid && wr_ready;
  assign can_load = !wr_valid || wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid   <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      frame_done <= 1'b0;
    end else if (!enable) begin
      wr_valid   <= 1'b0;
      wr_addr    <= '0;
      frame_done <= 1'b0;
    end else begin
      if (xfer) wr_addr <= wr_addr + 1'b1;
      if (byte_stb && can_load) begin
        wr_data  <= byte_val;
        wr_valid <= 1'b1;
      end else if (xfer) begin
        wr_valid <= 1'b0;
      end
      frame_done <= last_stb && can_load;
    end
  end
endmodule

// File: rtl/hdr_frame_rx.sv
module hdr_frame_rx
  import frx_pkg::*;
#(
  parameter int BUF_DEPTH = 8,
  parameter int LEN_W     = 8,
  localparam int ADDR_W   = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              sync_mode,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic [HDR_W-1:0]  hdr_pattern,
  input  logic [HDR_W-1:0]  hdr_mask,
  input  logic [LEN_W-1:0]  frame_len,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              frame_done
);
  logic              bit_stb, bit_val, byte_stb, last_stb;
  logic [BYTE_W-1:0] byte_val;

  frx_edge_sync u_sync (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .bit_stb(bit_stb), .bit_val(bit_val)
  );

  frx_deframer #(.LEN_W(LEN_W)) u_deframe (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sync_mode(sync_mode),
    .hdr_pattern(hdr_pattern), .hdr_mask(hdr_mask), .frame_len(frame_len),
    .bit_stb(bit_stb), .bit_val(bit_val),
    .byte_stb(byte_stb), .byte_val(byte_val), .last_stb(last_stb)
  );

  frx_wr_port #(.ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .byte_stb(byte_stb), .byte_val(byte_val), .last_stb(last_stb),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .frame_done(frame_done)
  );
endmodule

// File: rtl/frx_chk.sv
module frx_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              sync_mode,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              frame_done
);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable && wr_valid && !wr_ready |=> !enable || ($stable(wr_data) && $stable(wr_addr) && wr_valid));

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable && wr_valid && wr_ready |=> wr_addr == ADDR_W'($past(wr_addr) + 1'b1));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R6
  done_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> wr_valid && $past(sync_mode));

  // R9
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !wr_valid && wr_addr == '0 && !frame_done);
endmodule

bind hdr_frame_rx frx_chk #(.ADDR_W(ADDR_W)) u_frx_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .sync_mode(sync_mode),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .wr_data(wr_data), .frame_done(frame_done)
);

// File: tb/test_hdr_frame_rx.sv
`timescale 1ns/1ps
module test_hdr_frame_rx;
  logic        clk = 0, rst_n = 0, enable = 0, sync_mode = 0;
  logic        ser_clk = 0, ser_dat = 0, wr_ready = 1;
  logic [15:0] hdr_pattern = 0, hdr_mask = 0;
  logic [7:0]  frame_len = 0;
  logic        wr_valid, frame_done;
  logic [2:0]  wr_addr;
  logic [7:0]  wr_data;

  int checks = 0, errors = 0;
  logic [7:0] cap_d [0:255];
  logic [2:0] cap_a [0:255];
  int cap_n = 0, done_n = 0;

  always #2.5 clk = ~clk;

  hdr_frame_rx i_hdr_frame_rx (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sync_mode(sync_mode),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .hdr_pattern(hdr_pattern),
    .hdr_mask(hdr_mask), .frame_len(frame_len), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_done(frame_done)
  );

  always @(posedge clk) begin
    if (rst_n && wr_valid && wr_ready && cap_n < 256) begin
      cap_d[cap_n] = wr_data;
      cap_a[cap_n] = wr_addr;
      cap_n = cap_n + 1;
    end
    if (rst_n && frame_done) done_n = done_n + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk) ser_dat = b;
    repeat (3) @(negedge clk);
    ser_clk = 1;
    repeat (4) @(negedge clk);
    ser_clk = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic restart(input logic mode);
    @(negedge clk) enable = 0;
    repeat (3) @(negedge clk);
    sync_mode = mode;
    enable = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(!wr_valid, "R9 reset valid", int'(wr_valid), 0);
    chk(wr_addr == 0, "R7 reset addr", int'(wr_addr), 0);
    chk(!frame_done, "R6 reset done", int'(frame_done), 0);
  endtask

  task automatic t_free;
    int b0;
    restart(1'b0);
    b0 = cap_n;
    send_byte(8'hA5);
    send_byte(8'h3C);
    repeat (10) @(negedge clk);
    chk(cap_n - b0 == 2, "R2 free count", cap_n - b0, 2);
    chk(cap_d[b0] == 8'hA5, "R1 msb first", int'(cap_d[b0]), 'hA5);
    chk(cap_d[b0+1] == 8'h3C, "R2 second byte", int'(cap_d[b0+1]), 'h3C);
    chk(cap_a[b0] == 0 && cap_a[b0+1] == 1, "R7 addr seq", int'(cap_a[b0+1]), 1);
  endtask

  task automatic t_wrap;
    int b0;
    restart(1'b0);
    b0 = cap_n;
    for (int k = 0; k < 9; k++) send_byte(8'(k + 8'h40));
    repeat (10) @(negedge clk);
    chk(cap_n - b0 == 9, "R7 wrap count", cap_n - b0, 9);
    chk(cap_a[b0+7] == 7, "R7 last slot", int'(cap_a[b0+7]), 7);
    chk(cap_a[b0+8] == 0, "R7 wrap to zero", int'(cap_a[b0+8]), 0);
    chk(cap_d[b0+8] == 8'h48, "R2 wrap data", int'(cap_d[b0+8]), 'h48);
  endtask

  task automatic t_sync_frame;
    int b0, d0;
    hdr_pattern = 16'hB5E1; hdr_mask = 16'hFFFF; frame_len = 8'd2;
    restart(1'b1);
    b0 = cap_n; d0 = done_n;
    send_byte(8'h0F);
    send_byte(8'h6D);
    repeat (10) @(negedge clk);
    chk(cap_n == b0, "R3 nothing before header", cap_n - b0, 0);
    send_byte(8'hB5); send_byte(8'hE1);
    send_byte(8'h12); send_byte(8'h34);
    repeat (10) @(negedge clk);
    chk(cap_n - b0 == 2, "R5 frame count", cap_n - b0, 2);
    chk(cap_d[b0] == 8'h12 && cap_d[b0+1] == 8'h34, "R3 frame data", int'(cap_d[b0+1]), 'h34);
    chk(done_n - d0 == 1, "R6 one done pulse", done_n - d0, 1);
    send_byte(8'h77); send_byte(8'h00);
    repeat (10) @(negedge clk);
    chk(cap_n - b0 == 2, "R5 tail ignored", cap_n - b0, 2);
    send_byte(8'hB5); send_byte(8'hE1);
    send_byte(8'h9A); send_byte(8'hBC);
    repeat (10) @(negedge clk);
    chk(cap_n - b0 == 4 && cap_d[b0+2] == 8'h9A, "R5 second frame", cap_n - b0, 4);
    chk(done_n - d0 == 2, "R6 second done", done_n - d0, 2);
  endtask

  task automatic t_mask;
    int b0;
    hdr_pattern = 16'hAB00; hdr_mask = 16'hFF00; frame_len = 8'd1;
    restart(1'b1);
    b0 = cap_n;
    send_byte(8'hAB); send_byte(8'h37); send_byte(8'hD2);
    repeat (10) @(negedge clk);
    chk(cap_n - b0 == 1 && cap_d[b0] == 8'hD2, "R3 masked compare", int'(cap_d[b0]), 'hD2);
  endtask

  task automatic t_gate15;
    int b0;
    hdr_pattern = 16'h005A; hdr_mask = 16'h00FF; frame_len = 8'd1;
    restart(1'b1);
    b0 = cap_n;
    send_byte(8'h5A); send_byte(8'h00);
    send_byte(8'h5A); send_byte(8'hC3);
    repeat (10) @(negedge clk);
    chk(cap_n - b0 == 1, "R4 gate count", cap_n - b0, 1);
    chk(cap_d[b0] == 8'hC3, "R4 no early sync", int'(cap_d[b0]), 'hC3);
  endtask

  task automatic t_stall;
    int b0;
    restart(1'b0);
    b0 = cap_n;
    wr_ready = 0;
    send_byte(8'h11); send_byte(8'h22);
    repeat (10) @(negedge clk);
    chk(wr_valid && wr_data == 8'h11, "R8 held byte", int'(wr_data), 'h11);
    chk(wr_addr == 0, "R8 held addr", int'(wr_addr), 0);
    wr_ready = 1;
    repeat (4) @(negedge clk);
    chk(cap_n - b0 == 1 && !wr_valid, "R8 drop second", cap_n - b0, 1);
    chk(wr_addr == 1, "R8 one slot used", int'(wr_addr), 1);
  endtask

  task automatic t_disable;
    int b0;
    hdr_pattern = 16'hC0DE; hdr_mask = 16'hFFFF; frame_len = 8'd4;
    restart(1'b1);
    send_byte(8'hC0); send_byte(8'hDE);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    restart(1'b1);
    b0 = cap_n;
    chk(wr_addr == 0 && !wr_valid, "R9 cleared port", int'(wr_addr), 0);
    send_byte(8'h55); send_byte(8'h66);
    repeat (10) @(negedge clk);
    chk(cap_n == b0, "R9 lock dropped", cap_n - b0, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_free();
    t_wrap();
    t_sync_frame();
    t_mask();
    t_gate15();
    t_stall();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #900us;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule